// File: doc/BRIEF.md
# Power Sequencing and Select-Toggle Watchdog Supervisor

This block drives the power-related outputs of a battery-backed timekeeping peripheral: the supply-enable output, the gated clock output and the active-low CPU reset. It also tells the serial port whether it may run. It decides between a single-supply mode and a battery-backup mode from the level of a digital "system supply good" input. That level is sampled in the first clock after the internal reset is released. The block then follows the supply as it drops and returns.

Software can request a power-down with a one-cycle command strobe. The power-down state is held until the supply-good input shows a rising edge, or until an enabled alarm or periodic interrupt request arrives while the supply is good. A line-sense counter reports a line loss when a digital "line within window" input stays high for a delay of about 3.6 ms. A watchdog must be serviced by toggling the chip select with no serial clock activity during the select. If it is not serviced in time, the block pulses the CPU reset.

Top module: `pwr_supervisor`

## Requirements
- R1: In the running state, a `pd_cmd` strobe makes `pse`, `clkout`, `cpu_rst_n` and `serial_en` all 0 from the next clock edge.
- R2: The power-down state ends on the first edge at which `sys_good` is 1 and either was 0 in the previous cycle, or sees (`alarm_irq` and `alarm_en`) or (`per_irq` and `per_en`). A request with its enable at 0, or a request while `sys_good` is 0, leaves all outputs at 0.
- R3: The internal reset is released two edges after `rst_n` rises, and the following edge samples `sys_good`. If it is 1, single-supply mode is chosen and `pse`, `cpu_rst_n` and `serial_en` go to 1 after that edge. If it is 0, battery-backup mode is chosen and all outputs stay 0 until an edge sees `sys_good` = 1, after which they go to 1.
- R4: While running, `sys_good` = 0 forces `cpu_rst_n` and `serial_en` to 0 in either mode. In single-supply mode `pse` stays 1. In battery-backup mode `pse` and `clkout` also go to 0.
- R5: With `psense_en` = 1, `line_loss` is a one-cycle pulse after LINE_TERM consecutive edges with `line_in_win` = 1. LINE_TERM is floor(CLK_HZ·LINE_DLY_US/10^6), which is 119 at the defaults (32768 Hz, 3660 us). Any edge with `line_in_win` = 0 restarts the count, and the pulse is not repeated while the line stays inside the window.
- R6: With `psense_en` = 0, `line_loss` stays 0 whatever `line_in_win` does.
- R7: With `wdog_en` = 1 in the running state, WD_SVC_CYC (4096) edges without service drive `cpu_rst_n` to 0 for WD_PULSE_CYC (16) cycles and raise `wd_trip` for one cycle. The timer then restarts.
- R8: A rising edge of `sel_n` services the watchdog and restarts its timer, but only if `sck_act` was 0 on every cycle since `sel_n` fell. A select cycle with `sck_act` = 1 gives no service.
- R9: When `clk_sel` is between 0 and 6, `clkout` is a square wave with a period of 2^(`clk_sel`+1) clock cycles. When `clk_sel` is 7, `clkout` is 0.
- R10: `clkout` is 0 whenever `pse` is 0, including during power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_good | input | 1 | System supply above threshold |
| line_in_win | input | 1 | Line voltage inside the sense window |
| pd_cmd | input | 1 | One-cycle software power-down command |
| psense_en | input | 1 | Line-sense enable |
| wdog_en | input | 1 | Watchdog enable |
| alarm_irq | input | 1 | Alarm interrupt request |
| alarm_en | input | 1 | Alarm interrupt enable |
| per_irq | input | 1 | Periodic interrupt request |
| per_en | input | 1 | Periodic interrupt enable |
| sel_n | input | 1 | Serial chip select, active low |
| sck_act | input | 1 | Serial clock activity strobe |
| clk_sel | input | 3 | Clock output divide select |
| pse | output | 1 | Power supply enable |
| clkout | output | 1 | Divided clock output |
| cpu_rst_n | output | 1 | CPU reset, active low |
| serial_en | output | 1 | Serial port enable |
| line_loss | output | 1 | Line-loss status set pulse |
| wd_trip | output | 1 | Watchdog status set pulse |

## Verification
The sequencer outputs decode directly from the state register, so every command, wake-up or supply change shows up one edge after it is sampled. The bench drives inputs at the falling edge and samples at the next falling edge. The supply-good input also acts on `cpu_rst_n` within the same cycle, and the mode-table rows include that case. The line-loss pulse is due exactly LINE_TERM edges after the line enters the window. The watchdog trip is due exactly WD_SVC_CYC edges after enable. The bench counts edges from the point of stimulus and checks both the cycle before each event and the cycle of the event. The clock divider is checked by measuring the spacing between successive rising edges of `clkout`.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
  typedef enum logic [1:0] {
    PS_INIT = 2'd0,
    PS_RUN  = 2'd1,
    PS_DOWN = 2'd2,
    PS_OFF  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_good,
  input  logic       pd_cmd,
  input  logic       wake_irq,
  output pwr_state_e state,
  output logic       mode_single
);
  pwr_state_e state_q, state_d;
  logic       single_q, single_d;
  logic       sys_prev_q;
  logic       sys_rise;

  assign sys_rise = sys_good & ~sys_prev_q;

  always_comb begin
    state_d  = state_q;
    single_d = single_q;
    unique case (state_q)
      PS_INIT: begin
        single_d = sys_good;
        state_d  = sys_good ? PS_RUN : PS_OFF;
      end
      PS_RUN: begin
        if (pd_cmd)                      state_d = PS_DOWN;
        else if (!sys_good && !single_q) state_d = PS_OFF;
      end
      PS_DOWN: begin
        if (sys_rise || (sys_good && wake_irq)) state_d = PS_RUN;
      end
      PS_OFF: begin
        if (sys_good) state_d = PS_RUN;
      end
      default: state_d = PS_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_INIT;
      single_q   <= 1'b0;
      sys_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      single_q   <= single_d;
      sys_prev_q <= sys_good;
    end
  end

  assign state       = state_q;
  assign mode_single = single_q;
endmodule

// File: rtl/line_sense.sv
module line_sense #(
  parameter int unsigned TERM = 119
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic in_win,
  output logic loss
);
  localparam int CNT_W = $clog2(TERM + 1);
  localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(TERM - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             loss_q, loss_d;

  always_comb begin
    cnt_d  = cnt_q;
    loss_d = 1'b0;
    if (!enable || !in_win) begin
      cnt_d = '0;
    end else if (cnt_q != TERM_V) begin
      cnt_d  = cnt_q + 1'b1;
      loss_d = (cnt_q == LAST_V);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      loss_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      loss_q <= loss_d;
    end
  end

  assign loss = loss_q;
endmodule

// File: rtl/sel_watchdog.sv
module sel_watchdog #(
  parameter int unsigned SVC_CYC   = 4096,
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic enable,
  input  logic sel_n,
  input  logic sck_act,
  output logic cpu_rst,
  output logic trip
);
  localparam int CNT_W = $clog2(SVC_CYC);
  localparam int PLS_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(SVC_CYC - 1);
  localparam logic [PLS_W-1:0] PULSE_V = PLS_W'(PULSE_CYC);

  logic             sel_q;
  logic             dirty_q, dirty_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PLS_W-1:0] left_q, left_d;
  logic             trip_q, trip_d;
  logic             sel_rise, sel_fall, service;

  assign sel_rise = sel_n & ~sel_q;
  assign sel_fall = ~sel_n & sel_q;
  assign service  = sel_rise & ~dirty_q;

  always_comb begin
    dirty_d = dirty_q;
    if (sel_fall)              dirty_d = sck_act;
    else if (!sel_n && sck_act) dirty_d = 1'b1;
  end

  always_comb begin
    cnt_d  = cnt_q;
    left_d = left_q;
    trip_d = 1'b0;
    if (!active || !enable) begin
      cnt_d  = '0;
      left_d = '0;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
      cnt_d  = '0;
    end else if (service) begin
      cnt_d = '0;
    end else if (cnt_q == LAST_V) begin
      cnt_d  = '0;
      left_d = PULSE_V;
      trip_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b1;
      dirty_q <= 1'b0;
      cnt_q   <= '0;
      left_q  <= '0;
      trip_q  <= 1'b0;
    end else begin
      sel_q   <= sel_n;
      dirty_q <= dirty_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      trip_q  <= trip_d;
    end
  end

  assign cpu_rst = (left_q != '0);
  assign trip    = trip_q;
endmodule

// File: rtl/clk_div.sv
module clk_div #(
  parameter int NUM_DIV = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(NUM_DIV+1)-1:0] sel,
  output logic                       div_out
);
  localparam int SEL_W = $clog2(NUM_DIV + 1);

  logic [NUM_DIV-1:0] cnt_q, cnt_d;
  logic [NUM_DIV-1:0] tap;

  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
    assign tap[g] = (sel == SEL_W'(g)) & cnt_q[g];
  end

  assign div_out = |tap;
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 32768,
  parameter int unsigned LINE_DLY_US  = 3660,
  parameter int unsigned WD_SVC_CYC   = 4096,
  parameter int unsigned WD_PULSE_CYC = 16,
  parameter int          NUM_DIV      = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_good,
  input  logic       line_in_win,
  input  logic       pd_cmd,
  input  logic       psense_en,
  input  logic       wdog_en,
  input  logic       alarm_irq,
  input  logic       alarm_en,
  input  logic       per_irq,
  input  logic       per_en,
  input  logic       sel_n,
  input  logic       sck_act,
  input  logic [2:0] clk_sel,
  output logic       pse,
  output logic       clkout,
  output logic       cpu_rst_n,
  output logic       serial_en,
  output logic       line_loss,
  output logic       wd_trip
);
  localparam longint unsigned LINE_PROD = longint'(CLK_HZ) * longint'(LINE_DLY_US);
  localparam int unsigned     LINE_TERM = int'(LINE_PROD / 64'd1000000);

  logic [1:0] rst_sync_q;
  logic       rst_i;
  pwr_state_e state;
  logic       mode_single;
  logic       wake_irq;
  logic       run;
  logic       wd_rst;
  logic       div_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign wake_irq = (alarm_irq & alarm_en) | (per_irq & per_en);

  pwr_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_i),
    .sys_good   (sys_good),
    .pd_cmd     (pd_cmd),
    .wake_irq   (wake_irq),
    .state      (state),
    .mode_single(mode_single)
  );

  assign run = (state == PS_RUN);

  line_sense #(.TERM(LINE_TERM)) u_line (
    .clk   (clk),
    .rst_n (rst_i),
    .enable(psense_en),
    .in_win(line_in_win),
    .loss  (line_loss)
  );

  sel_watchdog #(.SVC_CYC(WD_SVC_CYC), .PULSE_CYC(WD_PULSE_CYC)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_i),
    .active (run),
    .enable (wdog_en),
    .sel_n  (sel_n),
    .sck_act(sck_act),
    .cpu_rst(wd_rst),
    .trip   (wd_trip)
  );

  clk_div #(.NUM_DIV(NUM_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_i),
    .sel    (clk_sel),
    .div_out(div_bit)
  );

  assign pse       = run & (mode_single | sys_good);
  assign serial_en = run & sys_good;
  assign cpu_rst_n = run & sys_good & ~wd_rst;
  assign clkout    = pse & div_bit;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk
  import pwr_sup_pkg::*;
(
  input logic       clk,
  input logic       rst_i,
  input pwr_state_e state,
  input logic       sys_good,
  input logic       pd_cmd,
  input logic       psense_en,
  input logic       alarm_irq,
  input logic       alarm_en,
  input logic       per_irq,
  input logic       per_en,
  input logic       pse,
  input logic       clkout,
  input logic       cpu_rst_n,
  input logic       serial_en,
  input logic       line_loss,
  input logic       wd_trip
);
  logic wake_seen;
  assign wake_seen = (alarm_irq & alarm_en) | (per_irq & per_en);

  AST_PD_OUTS_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    (pd_cmd && state == PS_RUN) |=> (!pse && !cpu_rst_n && !serial_en && !clkout)); // R1
  AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    (state == PS_DOWN && !(sys_good && (!$past(sys_good) || wake_seen))) |=> (state == PS_DOWN)); // R2
  AST_OFF_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    (state == PS_OFF) |-> (!pse && !cpu_rst_n && !serial_en && !clkout)); // R3
  AST_SUPPLY_LOW_RESET: assert property (@(posedge clk) disable iff (!rst_i)
    !sys_good |-> (!cpu_rst_n && !serial_en)); // R4
  AST_LINE_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
    line_loss |=> !line_loss); // R5
  AST_LINE_DISABLED: assert property (@(posedge clk) disable iff (!rst_i)
    !psense_en |=> !line_loss); // R6
  AST_TRIP_RESET: assert property (@(posedge clk) disable iff (!rst_i)
    wd_trip |-> !cpu_rst_n); // R7
  AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_i)
    !pse |-> !clkout); // R10
endmodule

bind pwr_supervisor pwr_supervisor_chk u_chk (
  .clk      (clk),
  .rst_i    (rst_i),
  .state    (state),
  .sys_good (sys_good),
  .pd_cmd   (pd_cmd),
  .psense_en(psense_en),
  .alarm_irq(alarm_irq),
  .alarm_en (alarm_en),
  .per_irq  (per_irq),
  .per_en   (per_en),
  .pse      (pse),
  .clkout   (clkout),
  .cpu_rst_n(cpu_rst_n),
  .serial_en(serial_en),
  .line_loss(line_loss),
  .wd_trip  (wd_trip)
);

// File: tb/sim_pwr_supervisor.sv
module sim_pwr_supervisor;
  localparam time CLK_PERIOD = 10ns;
  localparam int LINE_T  = (32768 * 3660) / 1000000;
  localparam int WD_T    = 4096;
  localparam int WD_P    = 16;
  localparam int NV      = 12;
  // {pd, sys, alarm, alarm_en, per, per_en | pse, cpu_rst_n, serial_en}
  localparam logic [8:0] VEC [NV] = '{
    9'b010000_111, 9'b110000_000, 9'b011000_000, 9'b011100_111,
    9'b110000_000, 9'b000000_000, 9'b000011_000, 9'b010000_111,
    9'b000000_100, 9'b010000_111, 9'b110000_000, 9'b010011_111
  };

  logic clk = 1'b0;
  logic rst_n, sys_good, line_in_win, pd_cmd, psense_en, wdog_en;
  logic alarm_irq, alarm_en, per_irq, per_en, sel_n, sck_act;
  logic [2:0] clk_sel;
  logic pse, clkout, cpu_rst_n, serial_en, line_loss, wd_trip;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_supervisor u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset(logic sys);
    @(negedge clk);
    rst_n = 1'b0; sys_good = sys;
    step(3);
    chk("R3 reset pse", pse, 0);
    chk("R3 reset cpu_rst_n", cpu_rst_n, 0);
    chk("R3 reset serial_en", serial_en, 0);
    rst_n = 1'b1;
    step(2);
    chk("R3 still init", pse, 0);
    step(1);
  endtask

  task automatic period_of(output int per);
    int first; int cnt; logic prev;
    first = -1; per = -1; prev = clkout;
    for (int i = 0; i < 1000 && per < 0; i++) begin
      step(1);
      if (!prev && clkout) begin
        if (first < 0) first = i; else per = i - first;
      end
      prev = clkout;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int per; int hits;
    rst_n = 1'b0; sys_good = 1'b1; line_in_win = 1'b0; pd_cmd = 1'b0;
    psense_en = 1'b0; wdog_en = 1'b0; alarm_irq = 1'b0; alarm_en = 1'b0;
    per_irq = 1'b0; per_en = 1'b0; sel_n = 1'b1; sck_act = 1'b0; clk_sel = 3'd7;

    // R3 single-supply start
    do_reset(1'b1);
    chk("R3 single pse", pse, 1);
    chk("R3 single cpu_rst_n", cpu_rst_n, 1);

    // R1 R2 R4 table walk
    for (int v = 0; v < NV; v++) begin
      {pd_cmd, sys_good, alarm_irq, alarm_en, per_irq, per_en} = VEC[v][8:3];
      step(1);
      pd_cmd = 1'b0;
      chk($sformatf("R1/R2/R4 row %0d", v), {pse, cpu_rst_n, serial_en}, VEC[v][2:0]);
      chk($sformatf("R10 row %0d clkout", v), clkout, 0);
    end
    {alarm_irq, alarm_en, per_irq, per_en} = 4'b0;
    sys_good = 1'b1;
    step(1);

    // R9 divider
    foreach (VEC[s]) begin
      if (s == 0 || s == 2 || s == 6) begin
        clk_sel = 3'(s);
        step(2);
        period_of(per);
        chk($sformatf("R9 period sel %0d", s), per, 1 << (s + 1));
      end
    end
    clk_sel = 3'd7;
    hits = 0;
    for (int i = 0; i < 300; i++) begin step(1); hits += clkout; end
    chk("R9 sel 7 low", hits, 0);

    // R10 clkout gated in power-down
    clk_sel = 3'd0;
    pd_cmd = 1'b1; step(1); pd_cmd = 1'b0;
    hits = 0;
    for (int i = 0; i < 300; i++) begin step(1); hits += clkout; end
    chk("R10 clkout in power-down", hits, 0);
    sys_good = 1'b0; step(1); sys_good = 1'b1; step(1);
    chk("R2 supply edge wake", pse, 1);
    clk_sel = 3'd7;

    // R5 line sense
    psense_en = 1'b1; line_in_win = 1'b1;
    hits = 0;
    for (int i = 0; i < 60; i++) begin step(1); hits += line_loss; end
    line_in_win = 1'b0; step(1); hits += line_loss;
    line_in_win = 1'b1;
    for (int k = 1; k <= LINE_T + 40; k++) begin
      step(1);
      if (k == LINE_T - 1) chk("R5 before term", line_loss, 0);
      else if (k == LINE_T) chk("R5 at term", line_loss, 1);
      else hits += line_loss;
    end
    chk("R5 no early or repeat pulse", hits, 0);

    // R6 disabled sensing
    line_in_win = 1'b0; step(1);
    psense_en = 1'b0; line_in_win = 1'b1;
    hits = 0;
    for (int i = 0; i < 300; i++) begin step(1); hits += line_loss; end
    chk("R6 disabled no loss", hits, 0);
    line_in_win = 1'b0;

    // R7 R8 unserviced (select cycle with clock activity)
    wdog_en = 1'b1;
    for (int k = 1; k <= WD_T + WD_P + 2; k++) begin
      step(1);
      if (k == WD_T - 1) chk("R8 dirty toggle no service", cpu_rst_n, 1);
      if (k == WD_T) begin
        chk("R7 trip reset low", cpu_rst_n, 0);
        chk("R7 trip pulse", wd_trip, 1);
      end
      if (k == WD_T + 1) chk("R7 trip one cycle", wd_trip, 0);
      if (k == WD_T + WD_P - 1) chk("R7 pulse still low", cpu_rst_n, 0);
      if (k == WD_T + WD_P) chk("R7 pulse ends", cpu_rst_n, 1);
      sel_n   = !(k >= 100 && k < 104);
      sck_act = (k == 101);
    end
    wdog_en = 1'b0; step(2);

    // R8 clean toggle services
    wdog_en = 1'b1;
    hits = 0;
    for (int k = 1; k <= 6000; k++) begin
      step(1);
      hits += !cpu_rst_n;
      sel_n = !(k >= 2000 && k < 2003);
    end
    chk("R8 clean toggle services", hits, 0);
    wdog_en = 1'b0;

    // R3 R4 battery-backup mode
    do_reset(1'b0);
    chk("R3 battery pse low", pse, 0);
    step(5);
    chk("R3 battery cpu_rst_n low", cpu_rst_n, 0);
    sys_good = 1'b1; step(1);
    chk("R3 battery powered pse", pse, 1);
    chk("R3 battery powered cpu_rst_n", cpu_rst_n, 1);
    sys_good = 1'b0; step(1);
    chk("R4 battery drop pse", pse, 0);
    chk("R4 battery drop cpu_rst_n", cpu_rst_n, 0);
    sys_good = 1'b1; step(1);
    chk("R4 battery return", pse, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule